// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block keeps a small set of recently used page-table entries and turns a virtual page number into a physical frame number. Any slot can hold any translation, and every stored tag is compared against the request in the same cycle. Each slot carries an address-space identifier, so that translations of different processes can share the cache without a flush on every context switch. Each slot also carries a valid flag, referenced and modified flags, and a two-bit access permission.

A requester offers a lookup with a valid/ready handshake and gets back a registered response one cycle later: hit or miss, the frame number, a permission fault flag and the slot's referenced and modified flags as they stood before the request. The response has its own valid/ready pair. A lookup is accepted only when the response register is empty or is being drained in the same cycle, so back-pressure on the response stalls new lookups. After a miss, the walker writes the new translation through the fill port, which also uses valid/ready. Lookups take precedence over fills: `fill_ready` is low in any cycle in which a lookup is accepted. Two plain control pins invalidate either the whole cache or only the slots of one address space. While either pin is high, both ready signals are low.

A fill goes into a free slot whenever one exists. Only when every slot is in use does it overwrite the least recently used slot. A slot counts as used when it is filled and each time a lookup hits it and is allowed to complete.

Top module: `asid_tlb`

## Requirements
- R1: After reset every slot is invalid, `resp_valid` is 0, `lk_ready` and `fill_ready` are 1, and any lookup misses.
- R2: A lookup hits only when a slot is valid, its stored page number equals `lk_vpn` and its identifier equals `lk_asid`. On a hit the slot's frame number appears on `resp_pfn`, and `resp_valid` rises in the cycle after the lookup is accepted.
- R3: A translation filled under one identifier misses when it is looked up under any other identifier.
- R4: The access code on `lk_acc` is 00 = load, 01 = store, 10 = execute and 11 = reserved. The permission code is 00 = none, 01 = load only, 10 = load and store, 11 = load, store and execute. A hit whose access is not allowed by its permission (the reserved code is never allowed) returns `resp_hit`=1 and `resp_fault`=1. A store to a load-only page therefore faults.
- R5: `resp_ref` and `resp_mod` report the slot's flags as they stood before the lookup. An allowed hit sets the referenced flag, and an allowed store also sets the modified flag. A faulting hit changes neither flag.
- R6: While any slot is invalid, a fill evicts no valid translation.
- R7: When all slots are valid, a fill replaces the slot whose last fill or allowed hit is the oldest.
- R8: A pulse on `flush_all` invalidates every slot.
- R9: A pulse on `flush_asid_en` invalidates exactly the slots whose identifier equals `flush_asid` and leaves all other translations in place.
- R10: `lk_ready` is 0 while the response is held (`resp_valid`=1 and `resp_ready`=0) or while a flush pin is high. A held response stays stable until it is taken.
- R11: `fill_ready` is 0 in a cycle in which a lookup is accepted or a flush pin is high. A fill offered in such a cycle is accepted in a later cycle.
- R12: The fill word `fill_entry` is packed, from MSB to LSB, as identifier[3:0], valid, referenced, modified, permission[1:0], frame[19:0], for 29 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request offered |
| lk_ready | output | 1 | Lookup request can be taken |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_asid | input | 4 | Current address-space identifier |
| lk_acc | input | 2 | Access type: 00 load, 01 store, 10 execute |
| resp_valid | output | 1 | Response register holds a result |
| resp_ready | input | 1 | Consumer takes the response |
| resp_hit | output | 1 | Translation found |
| resp_fault | output | 1 | Hit whose access is not permitted |
| resp_pfn | output | 20 | Physical frame number of the hit |
| resp_ref | output | 1 | Referenced flag before the lookup |
| resp_mod | output | 1 | Modified flag before the lookup |
| fill_valid | input | 1 | New translation offered |
| fill_ready | output | 1 | New translation can be written |
| fill_vpn | input | VPN_W | Page number tag of the new translation |
| fill_entry | input | 29 | Packed entry word (layout in R12) |
| flush_all | input | 1 | Invalidate every slot |
| flush_asid_en | input | 1 | Invalidate the slots of one identifier |
| flush_asid | input | 4 | Identifier for the selective flush |

## Verification
A lookup result is due exactly one cycle after the accepting clock edge. The bench therefore raises the request on a falling edge, lets one rising edge accept it, and reads the response on the next falling edge. Fills and flushes take effect at the edge that accepts them, so their effect is checked only through later lookups. The ready levels are sampled on the falling edge that precedes the edge they gate. When the response is held, the bench waits one more cycle and checks that `resp_valid` is still high, that the held fields have not changed and that `lk_ready` is low. Every expected result comes from a reference model in the bench: a table of slots with a use timestamp, and a free-slot rule ahead of the oldest-timestamp rule.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int ASID_W  = 4;
  localparam int PFN_W   = 20;
  localparam int PROT_W  = 2;
  localparam int ENTRY_W = ASID_W + 3 + PROT_W + PFN_W;

  typedef struct packed {
    logic [ASID_W-1:0] asid;
    logic              valid;
    logic              refd;
    logic              dirty;
    logic [PROT_W-1:0] prot;
    logic [PFN_W-1:0]  pfn;
  } pte_t;

  localparam logic [1:0] ACC_LOAD  = 2'b00;
  localparam logic [1:0] ACC_STORE = 2'b01;
  localparam logic [1:0] ACC_EXEC  = 2'b10;

  localparam logic [1:0] PROT_NONE = 2'b00;
  localparam logic [1:0] PROT_RO   = 2'b01;
  localparam logic [1:0] PROT_RW   = 2'b10;
  localparam logic [1:0] PROT_RWX  = 2'b11;

  function automatic logic access_ok(input logic [1:0] prot, input logic [1:0] acc);
    logic ok;
    case (acc)
      ACC_LOAD:  ok = (prot != PROT_NONE);
      ACC_STORE: ok = (prot == PROT_RW) || (prot == PROT_RWX);
      ACC_EXEC:  ok = (prot == PROT_RWX);
      default:   ok = 1'b0;
    endcase
    return ok;
  endfunction
endpackage

// File: rtl/tlb_store.sv
module tlb_store
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [VPN_W-1:0]      look_vpn,
  input  logic [ASID_W-1:0]     look_asid,
  output logic [ENTRIES-1:0]    match_vec,
  output logic [ENTRIES-1:0]    valid_vec,
  output pte_t [ENTRIES-1:0]    ent_q,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [VPN_W-1:0]      wr_vpn,
  input  pte_t                  wr_pte,
  input  logic                  upd_en,
  input  logic [IDX_W-1:0]      upd_idx,
  input  logic                  upd_dirty,
  input  logic                  flush_all,
  input  logic                  flush_sel,
  input  logic [ASID_W-1:0]     flush_asid
);
  pte_t             ent_r [ENTRIES];
  logic [VPN_W-1:0] tag_r [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_r[i] <= '0;
        tag_r[i] <= '0;
      end else if (flush_all) begin
        ent_r[i].valid <= 1'b0;
      end else if (flush_sel && ent_r[i].asid == flush_asid) begin
        ent_r[i].valid <= 1'b0;
      end else if (wr_en && wr_idx == IDX_W'(i)) begin
        ent_r[i] <= wr_pte;
        tag_r[i] <= wr_vpn;
      end else if (upd_en && upd_idx == IDX_W'(i)) begin
        ent_r[i].refd <= 1'b1;
        if (upd_dirty) ent_r[i].dirty <= 1'b1;
      end
    end

    assign match_vec[i] = ent_r[i].valid && (tag_r[i] == look_vpn) &&
                          (ent_r[i].asid == look_asid);
    assign valid_vec[i] = ent_r[i].valid;
    assign ent_q[i]     = ent_r[i];

    // R9: a selective flush leaves no valid slot of the flushed identifier
    a_r9_sel_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_sel && !flush_all) |=> !(ent_r[i].valid && ent_r[i].asid == $past(flush_asid)));
  end

  // R8: a full flush empties the cache
  a_r8_flush_all_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (valid_vec == '0));

  // R6: a fill while a slot is free adds one valid slot and evicts nothing
  a_r6_fill_takes_free: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_pte.valid && !(&valid_vec) && !flush_all && !flush_sel)
      |=> ($countones(valid_vec) == $past($countones(valid_vec)) + 1));
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int ENTRIES = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  output logic [IDX_W-1:0] oldest_idx
);
  logic [IDX_W-1:0]   age_r [ENTRIES];
  logic [IDX_W-1:0]   touch_age;
  logic [ENTRIES-1:0] oldest_vec;

  assign touch_age = age_r[touch_idx];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_age
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        age_r[i] <= IDX_W'(i);
      end else if (touch_en) begin
        if (touch_idx == IDX_W'(i))   age_r[i] <= '0;
        else if (age_r[i] < touch_age) age_r[i] <= age_r[i] + 1'b1;
      end
    end
    assign oldest_vec[i] = (age_r[i] == IDX_W'(ENTRIES - 1));
  end

  always_comb begin
    oldest_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (oldest_vec[i]) oldest_idx = oldest_idx | IDX_W'(i);
  end

  // R7: ages remain a permutation, so exactly one slot is the oldest
  a_r7_single_oldest: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(oldest_vec));
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic [IDX_W-1:0]   lru_idx,
  output logic [IDX_W-1:0]   victim_idx
);
  logic [IDX_W-1:0] free_idx;
  logic             any_free;

  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
    end
    victim_idx = any_free ? free_idx : lru_idx;
  end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lk_valid,
  output logic               lk_ready,
  input  logic [VPN_W-1:0]   lk_vpn,
  input  logic [3:0]         lk_asid,
  input  logic [1:0]         lk_acc,
  output logic               resp_valid,
  input  logic               resp_ready,
  output logic               resp_hit,
  output logic               resp_fault,
  output logic [19:0]        resp_pfn,
  output logic               resp_ref,
  output logic               resp_mod,
  input  logic               fill_valid,
  output logic               fill_ready,
  input  logic [VPN_W-1:0]   fill_vpn,
  input  logic [28:0]        fill_entry,
  input  logic               flush_all,
  input  logic               flush_asid_en,
  input  logic [3:0]         flush_asid
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic               flushing, lk_fire, fill_fire;
  logic [ENTRIES-1:0] match_vec, valid_vec;
  pte_t [ENTRIES-1:0] ent_q;
  logic               hit;
  logic [IDX_W-1:0]   hit_idx, lru_idx, victim_idx;
  pte_t               hit_pte;
  logic               allowed, upd_en;

  assign flushing   = flush_all | flush_asid_en;
  assign lk_ready   = !flushing && (!resp_valid || resp_ready);
  assign lk_fire    = lk_valid && lk_ready;
  assign fill_ready = !flushing && !lk_fire;
  assign fill_fire  = fill_valid && fill_ready;

  tlb_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .look_vpn   (lk_vpn),
    .look_asid  (lk_asid),
    .match_vec  (match_vec),
    .valid_vec  (valid_vec),
    .ent_q      (ent_q),
    .wr_en      (fill_fire),
    .wr_idx     (victim_idx),
    .wr_vpn     (fill_vpn),
    .wr_pte     (pte_t'(fill_entry)),
    .upd_en     (upd_en),
    .upd_idx    (hit_idx),
    .upd_dirty  (lk_acc == ACC_STORE),
    .flush_all  (flush_all),
    .flush_sel  (flush_asid_en),
    .flush_asid (flush_asid)
  );

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (match_vec[i]) hit_idx = hit_idx | IDX_W'(i);
  end

  assign hit     = |match_vec;
  assign hit_pte = ent_q[hit_idx];
  assign allowed = access_ok(hit_pte.prot, lk_acc);
  assign upd_en  = lk_fire && hit && allowed;

  tlb_lru #(.ENTRIES(ENTRIES)) u_lru (
    .clk        (clk),
    .rst_n      (rst_n),
    .touch_en   (upd_en | fill_fire),
    .touch_idx  (fill_fire ? victim_idx : hit_idx),
    .oldest_idx (lru_idx)
  );

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .valid_vec  (valid_vec),
    .lru_idx    (lru_idx),
    .victim_idx (victim_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_fault <= 1'b0;
      resp_pfn   <= '0;
      resp_ref   <= 1'b0;
      resp_mod   <= 1'b0;
    end else if (lk_fire) begin
      resp_valid <= 1'b1;
      resp_hit   <= hit;
      resp_fault <= hit && !allowed;
      resp_pfn   <= hit ? hit_pte.pfn : '0;
      resp_ref   <= hit && hit_pte.refd;
      resp_mod   <= hit && hit_pte.dirty;
    end else if (resp_ready) begin
      resp_valid <= 1'b0;
    end
  end

  // R2: an accepted lookup is answered in the next cycle
  a_r2_one_cycle_answer: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fire |=> resp_valid);

  // R4: a fault is only reported together with a hit
  a_r4_fault_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_fault) |-> resp_hit);

  // R10: a held response does not change
  a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_hit) &&
      $stable(resp_fault) && $stable(resp_pfn)));

  // R11: lookups and fills never share a cycle
  a_r11_single_op: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_valid && lk_ready && fill_valid && fill_ready));
endmodule

// File: tb/asid_tlb_bench.sv
`timescale 1ns/1ps
module asid_tlb_bench;
  localparam int N  = 16;
  localparam int VW = 10;
  localparam int H  = 1024;

  logic clk = 0;
  logic rst_n = 0;
  logic lk_valid = 0, lk_ready;
  logic [VW-1:0] lk_vpn = '0;
  logic [3:0] lk_asid = '0;
  logic [1:0] lk_acc = '0;
  logic resp_valid, resp_ready = 1;
  logic resp_hit, resp_fault, resp_ref, resp_mod;
  logic [19:0] resp_pfn;
  logic fill_valid = 0, fill_ready;
  logic [VW-1:0] fill_vpn = '0;
  logic [28:0] fill_entry = '0;
  logic flush_all = 0, flush_asid_en = 0;
  logic [3:0] flush_asid = '0;

  always #4 clk = ~clk;

  asid_tlb #(.ENTRIES(N), .VPN_W(VW)) u_asid_tlb (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_vpn(lk_vpn),
    .lk_asid(lk_asid), .lk_acc(lk_acc),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_hit(resp_hit),
    .resp_fault(resp_fault), .resp_pfn(resp_pfn), .resp_ref(resp_ref),
    .resp_mod(resp_mod),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_vpn(fill_vpn),
    .fill_entry(fill_entry),
    .flush_all(flush_all), .flush_asid_en(flush_asid_en), .flush_asid(flush_asid)
  );

  int total = 0, bad = 0;
  bit done = 0;

  // reference model
  bit          m_v [N];
  bit          m_r [N];
  bit          m_m [N];
  logic [VW-1:0] m_vpn [N];
  logic [3:0]  m_asid [N];
  logic [1:0]  m_prot [N];
  logic [19:0] m_pfn [N];
  int          m_ts [N];
  int          now = 0;
  logic [VW-1:0] h_vpn [H];
  logic [3:0]  h_asid [H];
  int          h_cnt = 0;
  int          fills = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit perm(input logic [1:0] prot, input logic [1:0] acc);
    if (acc == 2'd0) return prot != 2'd0;
    if (acc == 2'd1) return prot >= 2'd2;
    if (acc == 2'd2) return prot == 2'd3;
    return 0;
  endfunction

  task automatic lookup(input logic [VW-1:0] vpn, input logic [3:0] asid,
                        input logic [1:0] acc, input string req);
    bit eh = 0, ef = 0, er = 0, em = 0;
    logic [19:0] ep = '0;
    for (int i = 0; i < N; i++) begin
      if (m_v[i] && m_vpn[i] == vpn && m_asid[i] == asid) begin
        eh = 1; ep = m_pfn[i]; er = m_r[i]; em = m_m[i];
        ef = !perm(m_prot[i], acc);
        if (!ef) begin
          m_r[i] = 1;
          if (acc == 2'd1) m_m[i] = 1;
          m_ts[i] = now; now++;
        end
      end
    end
    @(negedge clk);
    lk_vpn = vpn; lk_asid = asid; lk_acc = acc; lk_valid = 1;
    while (!lk_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    lk_valid = 0;
    chk(resp_valid && resp_hit == eh && resp_fault == ef && (!eh || resp_pfn == ep) &&
        resp_ref == er && resp_mod == em, req,
        {39'd0, resp_valid, resp_hit, resp_fault, resp_ref, resp_mod, resp_pfn},
        {39'd0, 1'b1, eh, ef, er, em, ep});
  endtask

  task automatic model_fill(input logic [VW-1:0] vpn, input logic [3:0] asid,
                            input logic [1:0] prot, input logic [19:0] pfn);
    int slot = -1;
    for (int i = 0; i < N; i++) if (!m_v[i] && slot < 0) slot = i;
    if (slot < 0) begin
      slot = 0;
      for (int i = 1; i < N; i++) if (m_ts[i] < m_ts[slot]) slot = i;
    end
    m_v[slot] = 1; m_r[slot] = 0; m_m[slot] = 0; m_vpn[slot] = vpn;
    m_asid[slot] = asid; m_prot[slot] = prot; m_pfn[slot] = pfn;
    m_ts[slot] = now; now++;
    if (h_cnt < H) begin h_vpn[h_cnt] = vpn; h_asid[h_cnt] = asid; h_cnt++; end
  endtask

  task automatic fill(input logic [3:0] asid, input logic [1:0] prot, input logic [19:0] pfn);
    logic [VW-1:0] vpn;
    vpn = VW'(fills * 7 + 3);
    fills++;
    model_fill(vpn, asid, prot, pfn);
    @(negedge clk);
    fill_vpn = vpn;
    fill_entry = {asid, 1'b1, 1'b0, 1'b0, prot, pfn};   // R12 layout
    fill_valid = 1;
    chk(fill_ready == 1'b1, "R11 fill_ready idle", {63'd0, fill_ready}, 64'd1);
    @(posedge clk);
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic sweep(input string req);
    for (int k = 0; k < h_cnt; k++) lookup(h_vpn[k], h_asid[k], 2'd0, req);
  endtask

  task automatic flush(input bit all, input logic [3:0] a);
    @(negedge clk);
    flush_all = all; flush_asid_en = !all; flush_asid = a;
    lk_valid = 1;
    #1;
    chk(lk_ready == 1'b0, "R10 lk_ready during flush", {63'd0, lk_ready}, 64'd0);
    chk(fill_ready == 1'b0, "R11 fill_ready during flush", {63'd0, fill_ready}, 64'd0);
    @(posedge clk);
    @(negedge clk);
    flush_all = 0; flush_asid_en = 0; lk_valid = 0;
    for (int i = 0; i < N; i++) if (all || m_asid[i] == a) m_v[i] = 0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    summary();
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_ts[i] = -i; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(resp_valid == 0 && lk_ready == 1 && fill_ready == 1, "R1 reset outputs",
        {61'd0, resp_valid, lk_ready, fill_ready}, 64'd3);
    lookup(10'd3, 4'd0, 2'd0, "R1 miss after reset");

    // fill every slot, four identifiers and four permissions
    for (int i = 0; i < N; i++) fill(4'(i % 4), 2'(i % 4), 20'(32'h1000 + i * 37));
    // R2 R4 R5: every slot under every access type, twice to see R/M flags
    for (int rep = 0; rep < 2; rep++)
      for (int k = 0; k < N; k++)
        for (int a = 0; a < 4; a++)
          lookup(h_vpn[k], h_asid[k], 2'(a), "R4 R5 permission and flags");
    // R3: wrong identifier misses
    for (int k = 0; k < N; k++)
      lookup(h_vpn[k], h_asid[k] + 4'd1, 2'd0, "R3 other identifier");

    // R7: full cache, fills evict the oldest
    for (int j = 0; j < 6; j++) fill(4'(j % 3), 2'd2, 20'(32'h5000 + j));
    sweep("R7 oldest evicted");

    // R10: response held under back-pressure
    @(negedge clk);
    resp_ready = 0;
    lookup(h_vpn[h_cnt-1], h_asid[h_cnt-1], 2'd0, "R10 held response");
    @(negedge clk);
    chk(resp_valid && lk_ready == 0 && resp_hit && resp_pfn == 20'h5005, "R10 hold",
        {43'd0, resp_valid, lk_ready, resp_pfn}, {43'd0, 1'b1, 1'b0, 20'h5005});
    resp_ready = 1;
    @(negedge clk);
    chk(resp_valid == 0, "R10 drained", {63'd0, resp_valid}, 64'd0);

    // R11: fill waits behind a lookup
    begin
      logic [VW-1:0] nv;
      nv = VW'(fills * 7 + 3);
      fills++;
      @(negedge clk);
      lk_vpn = h_vpn[h_cnt-1]; lk_asid = h_asid[h_cnt-1]; lk_acc = 2'd0; lk_valid = 1;
      fill_vpn = nv; fill_entry = {4'd1, 1'b1, 1'b0, 1'b0, 2'd3, 20'hABCDE}; fill_valid = 1;
      #1;
      chk(fill_ready == 0, "R11 fill blocked", {63'd0, fill_ready}, 64'd0);
      @(posedge clk);
      @(negedge clk);
      lk_valid = 0;
      for (int i = 0; i < N; i++)
        if (m_v[i] && m_vpn[i] == h_vpn[h_cnt-1] && m_asid[i] == h_asid[h_cnt-1]) begin
          m_r[i] = 1; m_ts[i] = now; now++;
        end
      #1;
      chk(fill_ready == 1, "R11 fill released", {63'd0, fill_ready}, 64'd1);
      @(posedge clk);
      @(negedge clk);
      fill_valid = 0;
      model_fill(nv, 4'd1, 2'd3, 20'hABCDE);
      lookup(nv, 4'd1, 2'd2, "R11 delayed fill landed");
    end

    // R9 selective flush, then R6 fills into free slots
    flush(0, 4'd1);
    sweep("R9 selective flush");
    for (int j = 0; j < 3; j++) fill(4'd1, 2'd1, 20'(32'h7000 + j));
    sweep("R6 free slot fill");

    // mixed traffic against the model
    for (int it = 0; it < 400; it++) begin
      int r;
      r = int'($urandom % 20);
      if (r < 13)
        lookup(h_vpn[$urandom % h_cnt], 4'($urandom % 4), 2'($urandom % 4), "R2 R7 mixed lookup");
      else if (r < 19)
        fill(4'($urandom % 4), 2'($urandom % 4), 20'($urandom));
      else
        flush(0, 4'($urandom % 4));
    end
    sweep("R7 R9 after mixed traffic");

    // R8 full flush
    flush(1, 4'd0);
    sweep("R8 full flush");

    summary();
  end
endmodule